// File: doc/BRIEF.md
# Word-Wide CRC-32 Accelerator

This block computes a running CRC-32 over a stream of 32-bit words that a host writes through a small register window. Each word written to the accumulator register is folded into the current checksum as a whole. Reading the same register returns the checksum so far. The generator is 0x04C11DB7, processed most-significant bit first, with no reflection of input or output and no final inversion. A control register restarts the accumulation. A byte-wide scratch register is kept apart from the checksum, so a restart leaves it alone.

Requests use a valid/ready handshake. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. While a word is being folded, `req_ready` stays low, and every request, read or write, waits until the fold is done. While a request waits, the host must hold `req_valid`, `req_write`, `req_addr` and `req_wdata` steady. Read data comes back as a one-cycle `rsp_valid` pulse in the cycle after the read transfers. The response channel has no back-pressure. All accesses are full words. Offsets are decoded from `req_addr[3:2]`, and any address with `req_addr[1:0]` not zero counts as unmapped.

Top module: `crc32_word_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. The accumulator (offset 0x0) reads 0xFFFFFFFF and the scratch register (offset 0x4) reads 0.
- R2: A write to offset 0x0 replaces the accumulator with the CRC of the 32-bit word, starting from the old accumulator value. The CRC uses polynomial 0x04C11DB7, most-significant bit first, no reflection and no final XOR. A later read of offset 0x0 returns the new value.
- R3: Successive writes to offset 0x0 chain: each fold starts from the result of the previous fold.
- R4: After a write to offset 0x0 transfers, `req_ready` is low for exactly 4 cycles and then returns high. No request transfers in those cycles.
- R5: A read that transfers produces `rsp_valid` = 1 with its data in the next cycle only. `rsp_valid` is 0 in every other cycle.
- R6: Offset 0x4 stores bits 7:0 of a write. Reads of offset 0x4 return those bits, with bits 31:8 reading as 0.
- R7: Writing offset 0x8 with bit 0 set reloads the accumulator with 0xFFFFFFFF and leaves the scratch register unchanged. Writing offset 0x8 with bit 0 clear changes nothing. Offset 0x8 always reads as 0.
- R8: Writes to offset 0xC, or to any address with bits 1:0 not zero, change no register. Reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can transfer this cycle (low while folding) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench aims at the fold itself. It uses each single-bit word and a set of chained words, and compares each result with a bit-serial CRC computed in the bench. A design that folded bytes in the wrong order or reflected them would miss on almost every vector. The bench counts the stall length after each accumulator write; an engine that finished a cycle early or late would show a stall other than 4. It sweeps all 256 scratch values with junk in the upper bits, then restarts the accumulator and checks that the scratch register is unchanged; an over-wide scratch register or a restart that cleared it would both show. Unmapped and misaligned addresses, and control writes with bit 0 clear, are checked to leave the checksum unchanged and to read back zero.

// File: rtl/crc32u_pkg.sv
package crc32u_pkg;
  localparam int unsigned SLOT_ACCUM   = 0;
  localparam int unsigned SLOT_SCRATCH = 1;
  localparam int unsigned SLOT_CTRL    = 2;
  localparam logic [31:0] CRC_POLY     = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED     = 32'hFFFF_FFFF;
endpackage

// File: rtl/crc32u_engine.sv
module crc32u_engine #(
  parameter int unsigned          DATA_W  = 32,
  parameter int unsigned          SLICE_W = 8,
  parameter logic [DATA_W-1:0]    POLY    = crc32u_pkg::CRC_POLY,
  parameter logic [DATA_W-1:0]    SEED    = crc32u_pkg::CRC_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clear,
  input  logic [DATA_W-1:0] word_in,
  output logic              busy,
  output logic [DATA_W-1:0] crc_out
);
  localparam int unsigned STEPS = DATA_W / SLICE_W;
  localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;

  // Fold one slice, most significant bit first.
  function automatic logic [DATA_W-1:0] fold_slice(input logic [DATA_W-1:0] c,
                                                   input logic [SLICE_W-1:0] s);
    logic [DATA_W-1:0] r;
    r = c ^ {s, {(DATA_W-SLICE_W){1'b0}}};
    for (int i = 0; i < int'(SLICE_W); i++) begin
      r = r[DATA_W-1] ? ((r << 1) ^ POLY) : (r << 1);
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= SEED;
      word_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      acc_q  <= fold_slice(acc_q, word_q[DATA_W-1 -: SLICE_W]);
      word_q <= word_q << SLICE_W;
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(STEPS-1)) busy_q <= 1'b0;
    end else if (start) begin
      word_q <= word_in;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (clear) begin
      acc_q <= SEED;
    end
  end

  assign busy    = busy_q;
  assign crc_out = acc_q;
endmodule

// File: rtl/crc32u_regif.sv
module crc32u_regif #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SCRATCH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] crc_val,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              start,
  output logic              clear
);
  import crc32u_pkg::*;
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]     idx;
  logic                 aligned, xfer, wr, rd;
  logic                 hit_acc, hit_scr, hit_ctl;
  logic [SCRATCH_W-1:0] scratch_q;
  logic [DATA_W-1:0]    rd_mux, rdata_q;
  logic                 rvalid_q;

  assign idx     = req_addr[ADDR_W-1:2];
  assign aligned = (req_addr[1:0] == 2'b00);
  assign hit_acc = aligned && (idx == IDX_W'(SLOT_ACCUM));
  assign hit_scr = aligned && (idx == IDX_W'(SLOT_SCRATCH));
  assign hit_ctl = aligned && (idx == IDX_W'(SLOT_CTRL));

  assign req_ready = !busy;
  assign xfer      = req_valid && req_ready;
  assign wr        = xfer && req_write;
  assign rd        = xfer && !req_write;

  assign start = wr && hit_acc;
  assign clear = wr && hit_ctl && req_wdata[0];

  always_comb begin
    rd_mux = '0;
    if (hit_acc)      rd_mux = crc_val;
    else if (hit_scr) rd_mux = {{(DATA_W-SCRATCH_W){1'b0}}, scratch_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      rvalid_q  <= 1'b0;
      rdata_q   <= '0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
      if (wr && hit_scr) scratch_q <= req_wdata[SCRATCH_W-1:0];
    end
  end

  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/crc32_word_unit.sv
module crc32_word_unit #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SLICE_W   = 8,
  parameter int unsigned SCRATCH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic              eng_busy, eng_start, eng_clear;
  logic [DATA_W-1:0] eng_crc;

  crc32u_regif #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SCRATCH_W(SCRATCH_W)
  ) regif_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(eng_busy), .crc_val(eng_crc),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .start(eng_start), .clear(eng_clear)
  );

  crc32u_engine #(
    .DATA_W(DATA_W), .SLICE_W(SLICE_W)
  ) engine_i (
    .clk(clk), .rst_n(rst_n),
    .start(eng_start), .clear(eng_clear), .word_in(req_wdata),
    .busy(eng_busy), .crc_out(eng_crc)
  );
endmodule

// File: rtl/crc32u_checker.sv
module crc32u_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata
);
  logic acc_wr, rd_go;
  logic [3:0] stall_cnt;

  assign acc_wr = req_valid && req_ready && req_write && (req_addr == '0);
  assign rd_go  = req_valid && req_ready && !req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_cnt <= '0;
    else if (!req_ready) stall_cnt <= stall_cnt + 1'b1;
    else stall_cnt <= '0;
  end

  a_r4_stall_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> !req_ready);
  a_r4_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt <= 4'd4);
  a_r5_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rsp_valid);
  a_r5_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> !rsp_valid);
  a_r7_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && req_addr == ADDR_W'(8)) |=> (rsp_rdata == '0));
  a_r6_scratch_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && req_addr == ADDR_W'(4)) |=> (rsp_rdata[DATA_W-1:8] == '0));
endmodule

bind crc32_word_unit crc32u_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
);

// File: tb/crc32_word_unit_tb_top.sv
`timescale 1ns/1ps
module crc32_word_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int vectors = 0;
  int misses  = 0;

  always #4 clk = ~clk;

  crc32_word_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int i = 31; i >= 0; i--) begin
      logic fb = r[31] ^ d[i];
      r = r << 1;
      if (fb) r = r ^ 32'h04C1_1DB7;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R5 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
    @(negedge clk);
    check("R5 rsp_valid drop", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [31:0] rd, exp_crc;
    int stall;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", {31'b0, req_ready}, 32'd1);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    bus_rd(4'h0, rd); check("R1 accum", rd, 32'hFFFF_FFFF);
    bus_rd(4'h4, rd); check("R1 scratch", rd, 32'h0);

    // R2, R4: single-bit words from a fresh seed
    for (int b = 0; b < 32; b++) begin
      bus_wr(4'h8, 32'h1);
      bus_wr(4'h0, 32'h1 << b);
      stall = 0;
      while (!req_ready) begin stall++; @(negedge clk); end
      check("R4 stall", stall, 32'd4);
      bus_rd(4'h0, rd);
      check("R2 walking one", rd, ref_crc(32'hFFFF_FFFF, 32'h1 << b));
    end

    // R3: chained words
    bus_wr(4'h8, 32'h1);
    exp_crc = 32'hFFFF_FFFF;
    for (int k = 0; k < 24; k++) begin
      logic [31:0] w = (32'h9E37_79B9 * (k + 1)) ^ (32'h1 << k);
      bus_wr(4'h0, w);
      exp_crc = ref_crc(exp_crc, w);
      if (k % 3 == 2) begin bus_rd(4'h0, rd); check("R3 chain", rd, exp_crc); end
    end
    // back-to-back write then read, no idle gap in the bench
    bus_wr(4'h0, 32'hDEAD_BEEF);
    exp_crc = ref_crc(exp_crc, 32'hDEAD_BEEF);
    bus_rd(4'h0, rd); check("R3 write then read", rd, exp_crc);

    // R6: scratch sweep with junk upper bits
    for (int v = 0; v < 256; v++) begin
      bus_wr(4'h4, {24'hA5C3E1, 8'(v)});
      bus_rd(4'h4, rd);
      check("R6 scratch", rd, {24'h0, 8'(v)});
    end

    // R7: control behaviour
    bus_wr(4'h4, 32'h5A);
    bus_wr(4'h8, 32'hFFFF_FFFE);
    bus_rd(4'h0, rd); check("R7 bit0 clear no effect", rd, exp_crc);
    bus_rd(4'h8, rd); check("R7 ctrl reads zero", rd, 32'h0);
    bus_wr(4'h8, 32'h1);
    bus_rd(4'h0, rd); check("R7 reseed", rd, 32'hFFFF_FFFF);
    bus_rd(4'h4, rd); check("R7 scratch kept", rd, 32'h5A);

    // R8: unmapped and misaligned
    bus_wr(4'h0, 32'h1234_5678);
    exp_crc = ref_crc(32'hFFFF_FFFF, 32'h1234_5678);
    bus_wr(4'hC, 32'hFFFF_FFFF);
    bus_wr(4'h1, 32'h0BAD_F00D);
    bus_wr(4'h9, 32'h1);
    bus_wr(4'h6, 32'h77);
    bus_rd(4'h0, rd); check("R8 accum untouched", rd, exp_crc);
    check("R8 ready after misaligned", {31'b0, req_ready}, 32'd1);
    bus_rd(4'h4, rd); check("R8 scratch untouched", rd, 32'h5A);
    bus_rd(4'hC, rd); check("R8 read 0xC", rd, 32'h0);
    bus_rd(4'h1, rd); check("R8 read misaligned", rd, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule